// File: doc/BRIEF.md
# Watchdog Timer with Guarded Shutdown

This block is a watchdog timer configured through a single 8-bit control register. Software turns it on by writing the enable bit. While it is on, the watchdog counts ticks that come from a slow oscillator as a one-cycle tick-enable. If the count reaches the selected timeout before software kicks the timer, the block asks for a system reset with a one-cycle pulse and then starts counting again from zero. The timeout is the parameter `BASE_CYCLES` shifted left by the 3-bit select field, so the default gives 16K to 2048K oscillator ticks.

Turning the watchdog on is always allowed. Turning it off, or changing the timeout select, needs an unlock window first. A write with the unlock bit set opens the window for the four system clock cycles that follow. A second write inside that window may then clear the enable bit or load a new select value. When the safety-level input reads 2, the enable bit cannot be cleared at all.

The unlock logic is a two-state machine. `WIN_SHUT` goes to `WIN_OPEN` on any arming write. `WIN_OPEN` stays open while its down-counter runs, and an arming write reloads it to four. It returns to `WIN_SHUT` when the counter expires. The timeout logic is a three-state machine. `WD_OFF` goes to `WD_RUN` when enable is set. `WD_RUN` goes to `WD_FIRE` on the final tick, and back to `WD_OFF` when enable clears. `WD_FIRE` always leaves after one cycle, to `WD_RUN` or to `WD_OFF`.

Top module: `wdt_guard`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00 and `rst_req` is low, so the watchdog starts disabled.
- R2: Bits 7:5 of `reg_rdata` always read zero, whatever has been written to them.
- R3: A write with bit 3 (enable) set makes bit 3 read one from the next cycle on, whether or not the window is open.
- R4: A write with bit 4 (unlock) set makes bit 4 read one for exactly the four cycles after that write, then zero. An arming write during an open window restarts the four-cycle count.
- R5: A write with bit 3 clear clears the enable bit only if the window was open when the write happened. In practice that write falls in one of the four cycles after the arming write. A write in the fifth cycle or later leaves enable at one.
- R6: While `safety_level` equals 2, no write clears the enable bit, even with a correct unlock sequence.
- R7: Bits 2:0 (timeout select n) load from a write only while the window is open. Otherwise they keep their value.
- R8: While the watchdog is enabled, `BASE_CYCLES << n` counted ticks with no clear in between drive `rst_req` high for exactly one cycle. That cycle follows the edge that takes the final tick. A tick in the pulse cycle is not counted, and counting then restarts from zero.
- R9: A kick, any register write, or a disabled watchdog clears the tick count. `rst_req` never rises while the watchdog is disabled, or in the cycle after a kick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe (register select) |
| reg_wdata | input | 8 | Write data: [4] unlock, [3] enable, [2:0] timeout select |
| reg_rdata | output | 8 | Read data: {000, unlock, enable, select} |
| kick | input | 1 | Watchdog clear |
| osc_tick | input | 1 | Tick-enable from the slow watchdog oscillator |
| safety_level | input | 2 | Safety level; value 2 forbids disabling |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Some properties are checked on every cycle:
- The reserved bits read zero.
- The pulse lasts one cycle.
- No pulse appears while the watchdog is disabled or right after a kick.
- The enable bit survives any write made while the window is closed or while `safety_level` is 2.
- The select field holds steady while the window is closed.
- Arming and enabling writes take effect on the next cycle.

Other behaviour needs the bench's scenarios, run against a cycle model of the requirements:
- the exact length of the window, including the fourth-cycle and fifth-cycle boundary and the restart;
- the exact tick count to the first pulse;
- the uncounted tick in the pulse cycle;
- random mixes of writes, kicks and safety changes.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

    localparam int REG_W    = 8;
    localparam int UNLK_BIT = 4;
    localparam int ENA_BIT  = 3;
    localparam int SEL_LO   = 0;
    localparam logic [1:0] SAFETY_LOCKED = 2'd2;

    typedef enum logic {
        WIN_SHUT,
        WIN_OPEN
    } win_state_t;

    typedef enum logic [1:0] {
        WD_OFF,
        WD_RUN,
        WD_FIRE
    } wd_state_t;

endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock #(
    parameter int WIN_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic open
);
    import wdt_guard_pkg::*;

    localparam int WC_W = $clog2(WIN_CYCLES + 1);

    win_state_t        state_q, state_d;
    logic [WC_W-1:0]   left_q, left_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WIN_SHUT;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        if (arm) begin
            state_d = WIN_OPEN;
            left_d  = WC_W'(WIN_CYCLES);
        end else begin
            unique case (state_q)
                WIN_SHUT: begin
                    left_d = '0;
                end
                WIN_OPEN: begin
                    if (left_q <= WC_W'(1)) begin
                        state_d = WIN_SHUT;
                        left_d  = '0;
                    end else begin
                        left_d = left_q - WC_W'(1);
                    end
                end
                default: begin
                    state_d = WIN_SHUT;
                    left_d  = '0;
                end
            endcase
        end
    end

    assign open = (state_q == WIN_OPEN);

endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             wr_ena,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             win_open,
    input  logic             no_disable,
    output logic             ena,
    output logic [SEL_W-1:0] sel
);

    logic             ena_d;
    logic [SEL_W-1:0] sel_d;

    always_comb begin
        ena_d = ena;
        sel_d = sel;
        if (we) begin
            if (wr_ena) begin
                ena_d = 1'b1;
            end else if (win_open && !no_disable) begin
                ena_d = 1'b0;
            end
            if (win_open) begin
                sel_d = wr_sel;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena <= 1'b0;
            sel <= '0;
        end else begin
            ena <= ena_d;
            sel <= sel_d;
        end
    end

endmodule

// File: rtl/wdt_timeout.sv
module wdt_timeout #(
    parameter int BASE_CYCLES = 16384,
    parameter int SEL_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ena,
    input  logic             clr,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             fire
);
    import wdt_guard_pkg::*;

    localparam int CNT_W = $clog2(BASE_CYCLES) + (1 << SEL_W);

    wd_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] limit;
    logic             counting;
    logic             hit;

    assign limit    = CNT_W'(BASE_CYCLES) << sel;
    assign counting = ena && !clr && (state_q != WD_FIRE);
    assign hit      = tick && (cnt_q == limit - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WD_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF:  state_d = ena ? WD_RUN : WD_OFF;
            WD_RUN:  state_d = ena ? WD_RUN : WD_OFF;
            WD_FIRE: state_d = ena ? WD_RUN : WD_OFF;
            default: state_d = WD_OFF;
        endcase
        if (counting && hit) begin
            state_d = WD_FIRE;
        end

        if (!counting) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = hit ? '0 : cnt_q + CNT_W'(1);
        end else begin
            cnt_d = cnt_q;
        end
    end

    assign fire = (state_q == WD_FIRE);

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard #(
    parameter int BASE_CYCLES = 16384,
    parameter int SEL_W       = 3,
    parameter int WIN_CYCLES  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       kick,
    input  logic       osc_tick,
    input  logic [1:0] safety_level,
    output logic       rst_req
);
    import wdt_guard_pkg::*;

    logic             win_open;
    logic             ena;
    logic [SEL_W-1:0] sel;
    logic             arm;
    logic             clr;

    assign arm = reg_we && reg_wdata[UNLK_BIT];
    assign clr = kick || reg_we;

    wdt_unlock #(
        .WIN_CYCLES (WIN_CYCLES)
    ) u_unlock (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm),
        .open  (win_open)
    );

    wdt_ctrl_reg #(
        .SEL_W (SEL_W)
    ) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (reg_we),
        .wr_ena     (reg_wdata[ENA_BIT]),
        .wr_sel     (reg_wdata[SEL_LO +: SEL_W]),
        .win_open   (win_open),
        .no_disable (safety_level == SAFETY_LOCKED),
        .ena        (ena),
        .sel        (sel)
    );

    wdt_timeout #(
        .BASE_CYCLES (BASE_CYCLES),
        .SEL_W       (SEL_W)
    ) u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .ena   (ena),
        .clr   (clr),
        .tick  (osc_tick),
        .sel   (sel),
        .fire  (rst_req)
    );

    always_comb begin
        reg_rdata                    = '0;
        reg_rdata[UNLK_BIT]          = win_open;
        reg_rdata[ENA_BIT]           = ena;
        reg_rdata[SEL_LO +: SEL_W]   = sel;
    end

endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       kick,
    input logic [1:0] safety_level,
    input logic       rst_req
);

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7:5] == 3'b000); // R2

    AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && reg_wdata[3] |=> reg_rdata[3]); // R3

    AST_ARM_SET: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && reg_wdata[4] |=> reg_rdata[4]); // R4

    AST_EN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[3] && !reg_rdata[4] |=> reg_rdata[3]); // R5

    AST_SAFETY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[3] && safety_level == 2'd2 |=> reg_rdata[3]); // R6

    AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[4] |=> $stable(reg_rdata[2:0])); // R7

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R8

    AST_NO_REQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[3] |=> !rst_req); // R9

    AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !rst_req); // R9

endmodule

bind wdt_guard wdt_guard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .kick         (kick),
    .safety_level (safety_level),
    .rst_req      (rst_req)
);

// File: tb/sim_wdt_guard.sv
module sim_wdt_guard;

    localparam int BASE = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       kick = 1'b0;
    logic       osc_tick = 1'b0;
    logic [1:0] safety_level = 2'd0;
    logic       rst_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    wdt_guard #(.BASE_CYCLES(BASE), .SEL_W(3), .WIN_CYCLES(4)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (reg_we),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .kick         (kick),
        .osc_tick     (osc_tick),
        .safety_level (safety_level),
        .rst_req      (rst_req)
    );

    // reference model built from the requirements
    int       m_win;
    bit       m_en;
    bit [2:0] m_sel;
    int       m_cnt;
    bit       m_fire;

    function automatic int limit_of(input bit [2:0] s);
        return BASE << s;
    endfunction

    function automatic logic [7:0] exp_rd();
        return {3'b000, m_win != 0, m_en, m_sel};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_win = 0; m_en = 0; m_sel = 0; m_cnt = 0; m_fire = 0;
        end else begin
            bit open, en_old, clr, fire_n;
            bit [2:0] sel_old;
            open = (m_win != 0);
            en_old = m_en;
            sel_old = m_sel;
            clr = kick || reg_we;
            fire_n = 0;
            if (!en_old || clr || m_fire) m_cnt = 0;
            else if (osc_tick) begin
                if (m_cnt == limit_of(sel_old) - 1) begin m_cnt = 0; fire_n = 1; end
                else m_cnt = m_cnt + 1;
            end
            m_fire = fire_n;
            if (reg_we) begin
                if (reg_wdata[3]) m_en = 1;
                else if (open && safety_level != 2'd2) m_en = 0;
                if (open) m_sel = reg_wdata[2:0];
            end
            if (reg_we && reg_wdata[4]) m_win = 4;
            else if (m_win != 0) m_win = m_win - 1;
        end
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R5 model rdata", reg_rdata, exp_rd());
            chk("R8 model rst_req", {7'd0, rst_req}, {7'd0, m_fire});
        end
    end

    task automatic wr(input logic [7:0] d);
        reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        idle(3);
        chk("R1 reset rdata", reg_rdata, 8'h00);
        chk("R1 reset rst_req", {7'd0, rst_req}, 8'h00);
        rst_n = 1'b1;
        idle(1);

        wr(8'hE0);
        chk("R2 reserved bits", reg_rdata, 8'h00);
        wr(8'h08);
        chk("R3 enable set", reg_rdata, 8'h08);
        wr(8'h0D);
        chk("R7 select locked", reg_rdata, 8'h08);

        wr(8'h18);
        chk("R4 armed", reg_rdata, 8'h18);
        idle(3);
        chk("R4 fourth cycle open", {7'd0, reg_rdata[4]}, 8'h01);
        idle(1);
        chk("R4 closed after four", {7'd0, reg_rdata[4]}, 8'h00);

        wr(8'h18); idle(2); wr(8'h18); idle(3);
        chk("R4 restarted window", {7'd0, reg_rdata[4]}, 8'h01);
        idle(2);

        wr(8'h18); idle(3); wr(8'h00);
        chk("R5 disable in fourth cycle", reg_rdata, 8'h00);

        wr(8'h08); wr(8'h18); idle(4); wr(8'h00);
        chk("R5 disable too late", reg_rdata, 8'h08);

        wr(8'h18); wr(8'h0B);
        chk("R7 select in window", reg_rdata, 8'h1B);

        safety_level = 2'd2;
        idle(4); wr(8'h18); wr(8'h00);
        chk("R6 safety blocks disable", {7'd0, reg_rdata[3]}, 8'h01);
        safety_level = 2'd0;

        idle(4); wr(8'h18); wr(8'h0A); idle(5);
        osc_tick = 1'b1;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            chk("R8 before limit", {7'd0, rst_req}, 8'h00);
        end
        @(negedge clk);
        chk("R8 pulse at limit", {7'd0, rst_req}, 8'h01);
        @(negedge clk);
        chk("R8 pulse one cycle", {7'd0, rst_req}, 8'h00);
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            chk("R8 restart count", {7'd0, rst_req}, 8'h00);
        end
        @(negedge clk);
        chk("R8 second pulse", {7'd0, rst_req}, 8'h01);

        for (int i = 0; i < 100; i++) begin
            kick = (i % 10 == 0);
            @(negedge clk);
            chk("R9 kicked no pulse", {7'd0, rst_req}, 8'h00);
        end
        kick = 1'b0;
        osc_tick = 1'b0;
        idle(5); wr(8'h18); wr(8'h00);
        chk("R9 disabled", {7'd0, reg_rdata[3]}, 8'h00);
        osc_tick = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            chk("R9 off no pulse", {7'd0, rst_req}, 8'h00);
        end

        for (int i = 0; i < 8000; i++) begin
            reg_we    = ($urandom % 150 == 0);
            reg_wdata = 8'($urandom);
            kick      = ($urandom % 400 == 0);
            osc_tick  = 1'($urandom);
            if ($urandom % 1000 == 0) safety_level = 2'($urandom);
            if ($urandom % 500 == 0) begin
                reg_we = 1'b1; reg_wdata = 8'h18;
                @(negedge clk);
                reg_wdata = {5'b00000, 3'($urandom % 3)} | 8'($urandom & 8);
            end
            @(negedge clk);
        end
        reg_we = 1'b0; kick = 1'b0; osc_tick = 1'b0;
        idle(2);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule